// File: doc/BRIEF.md
# PLL Configuration Register Set

This block holds the software-visible settings of a clock-generator PLL behind a simple synchronous register port: an enable bit, a base-clock source select, an automatic-bandwidth mode, an interrupt enable, an interrupt flag, a VCO range multiplier and a reference divide code. It keeps software from changing the multiplier or the reference divide code while the PLL is running. It also refuses to route the VCO clock to the base clock while the multiplier is zero.

The lock indication from the analog loop comes in asynchronously. It is synchronized, and each change in either direction raises the interrupt flag when automatic mode is on. The block also contains the modulo reference divider. It counts reference strobes and emits one divided pulse per programmed factor.

Register map on `addr`: 0 = control, 1 = VCO range multiplier, 2 = reference divide code, 3 = reads zero and ignores writes. Control bit layout: bit 0 `pll_on`, bit 1 base select, bit 2 automatic mode, bit 3 interrupt enable, bit 4 interrupt flag. Bits 7:5 of the control register read 0.

Top module: `pll_cfg_regs`

## Requirements
- R1: After reset, control reads 0x00, the range register reads 0x40, the divide code register reads 0x01 and address 3 reads 0x00.
- R2: The divide code register keeps bits 3:0 only; bits 7:4 always read 0 whatever was written.
- R3: The divider emits one `ref_div_tick` pulse for every R `ref_tick` strobes, where R is the divide code and a code of 0 behaves as 1. Its count restarts from zero whenever the code changes.
- R4: A write to the divide code register has no effect while `pll_on` is 1.
- R5: A write to the range register has no effect while `pll_on` is 1.
- R6: Base select (control bit 1) can only be 1 while `pll_on` (bit 0) is 1. A control write that clears bit 0 also clears bit 1.
- R7: A control write that sets bit 1 leaves base select at 0 when the range register holds 0.
- R8: With automatic mode (bit 2) set, every rise or fall of `lock_in` sets the flag (bit 4), visible three clock edges after the input changes. With automatic mode clear, a change of `lock_in` leaves the flag unchanged.
- R9: The flag sets regardless of the interrupt enable (bit 3). `irq_req` is 1 exactly when both the flag and the enable are 1.
- R10: Writing 1 to control bit 4 clears the flag, and writing 0 there leaves it unchanged. If a lock change sets the flag in the same cycle as a clearing write, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| lock_in | input | 1 | Asynchronous lock indication from the loop |
| ref_tick | input | 1 | One-cycle reference clock strobe |
| pll_on | output | 1 | PLL enable |
| base_sel | output | 1 | Base clock taken from the VCO |
| vco_mult | output | 8 | VCO range multiplier |
| ref_div_tick | output | 1 | Divided reference pulse |
| irq_req | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that captures it. The bench therefore drives each write at a falling edge and reads `rdata` back one falling edge later, after that single register stage. A `lock_in` change passes two synchronizer flops and an edge register before it reaches the flag. The bench checks that the flag is still clear two edges after the change and set at the third edge, and it times the clearing write to land on that same third edge. `ref_div_tick` is registered, so each strobe's effect is sampled at the falling edge after the edge that took the strobe, and pulses are counted over exact windows of strobes.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
   localparam int ADDR_W      = 2;
   localparam int ADDR_CTRL   = 0;
   localparam int ADDR_RANGE  = 1;
   localparam int ADDR_REFDIV = 2;

   localparam int BIT_ON    = 0;
   localparam int BIT_SEL   = 1;
   localparam int BIT_AUTO  = 2;
   localparam int BIT_IE    = 3;
   localparam int BIT_FLAG  = 4;
   localparam int CTRL_BITS = 5;

   typedef struct packed {
      logic flag;
      logic ie;
      logic auto_bw;
      logic sel;
      logic on;
   } ctrl_t;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic changed
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pll_lock_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign changed = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/pll_ref_divider.sv
module pll_ref_divider #(
   parameter int          CODE_W   = 4,
   parameter logic [CODE_W-1:0] RST_CODE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic              ref_tick,
   output logic              div_tick
);
   logic [CODE_W-1:0] cnt_q;
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] last_cnt;
   logic              tick_q;

   if (CODE_W < 1) begin : g_bad_width
      $error("pll_ref_divider: CODE_W must be positive");
   end

   always_comb begin
      if (code == '0) last_cnt = '0;
      else            last_cnt = code - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         code_q <= RST_CODE;
         tick_q <= 1'b0;
      end else begin
         code_q <= code;
         if (code != code_q) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
         end else if (ref_tick) begin
            if (cnt_q == last_cnt) begin
               cnt_q  <= '0;
               tick_q <= 1'b1;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
               tick_q <= 1'b0;
            end
         end else begin
            tick_q <= 1'b0;
         end
      end
   end

   assign div_tick = tick_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (code == code_q) |-> (cnt_q <= last_cnt)); // R3
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
   import pll_cfg_pkg::*;
#(
   parameter int             DW          = 8,
   parameter int             RDS_W       = 4,
   parameter int             SYNC_STAGES = 2,
   parameter logic [DW-1:0]  RANGE_RST   = 8'h40,
   parameter logic [RDS_W-1:0] RDS_RST   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic              lock_in,
   input  logic              ref_tick,
   output logic              pll_on,
   output logic              base_sel,
   output logic [DW-1:0]     vco_mult,
   output logic              ref_div_tick,
   output logic              irq_req
);
   if (RDS_W < 1 || RDS_W > DW) begin : g_bad_rds
      $error("pll_cfg_regs: RDS_W must lie in 1..DW");
   end
   if (DW < CTRL_BITS) begin : g_bad_dw
      $error("pll_cfg_regs: DW too narrow for the control bits");
   end

   ctrl_t              ctrl_q;
   logic [DW-1:0]      range_q;
   logic [RDS_W-1:0]   rds_q;
   logic               lock_chg;
   logic               flag_set;
   logic               wr_ctrl, wr_range, wr_rds;

   assign wr_ctrl  = wr_en && (addr == ADDR_W'(ADDR_CTRL));
   assign wr_range = wr_en && (addr == ADDR_W'(ADDR_RANGE));
   assign wr_rds   = wr_en && (addr == ADDR_W'(ADDR_REFDIV));
   assign flag_set = ctrl_q.auto_bw && lock_chg;

   pll_lock_sync #(.STAGES(SYNC_STAGES)) i_lock_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (lock_in),
      .changed  (lock_chg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         range_q <= RANGE_RST;
         rds_q   <= RDS_RST;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.on      <= wdata[BIT_ON];
            ctrl_q.sel     <= wdata[BIT_ON] && wdata[BIT_SEL] && (range_q != '0);
            ctrl_q.auto_bw <= wdata[BIT_AUTO];
            ctrl_q.ie      <= wdata[BIT_IE];
         end
         if (flag_set)
            ctrl_q.flag <= 1'b1;
         else if (wr_ctrl && wdata[BIT_FLAG])
            ctrl_q.flag <= 1'b0;
         if (wr_range && !ctrl_q.on)
            range_q <= wdata;
         if (wr_rds && !ctrl_q.on)
            rds_q <= wdata[RDS_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(ADDR_CTRL):   rdata[CTRL_BITS-1:0] = ctrl_q;
         ADDR_W'(ADDR_RANGE):  rdata = range_q;
         ADDR_W'(ADDR_REFDIV): rdata[RDS_W-1:0] = rds_q;
         default:              rdata = '0;
      endcase
   end

   pll_ref_divider #(.CODE_W(RDS_W), .RST_CODE(RDS_RST)) i_ref_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .code     (rds_q),
      .ref_tick (ref_tick),
      .div_tick (ref_div_tick)
   );

   assign pll_on   = ctrl_q.on;
   assign base_sel = ctrl_q.sel;
   assign vco_mult = range_q;
   assign irq_req  = ctrl_q.flag && ctrl_q.ie;

   AST_RDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.on && wr_rds) |=> $stable(rds_q)); // R4
   AST_RANGE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.on && wr_range) |=> $stable(range_q)); // R5
   AST_SEL_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_on |-> !base_sel); // R6
   AST_SEL_NEEDS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      base_sel |-> (vco_mult != '0)); // R7
   AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.auto_bw && lock_chg) |=> ctrl_q.flag); // R8
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.flag && !(wr_ctrl && wdata[BIT_FLAG])) |=> ctrl_q.flag); // R10
endmodule

// File: tb/test_pll_cfg_regs.sv
`timescale 1ns/1ps
module test_pll_cfg_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       lock_in = 1'b0;
   logic       ref_tick = 1'b0;
   logic       pll_on, base_sel, ref_div_tick, irq_req;
   logic [7:0] vco_mult;

   int n_checks = 0;
   int n_fail   = 0;
   logic done = 1'b0;

   // model state
   logic       m_on, m_sel, m_auto, m_ie, m_flag;
   logic [7:0] m_range;
   logic [3:0] m_rds;

   always #2.5 clk = ~clk;

   pll_cfg_regs i_pll_cfg_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .lock_in(lock_in), .ref_tick(ref_tick), .pll_on(pll_on),
      .base_sel(base_sel), .vco_mult(vco_mult), .ref_div_tick(ref_div_tick),
      .irq_req(irq_req)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   function automatic logic [7:0] exp_ctrl();
      return {3'b000, m_flag, m_ie, m_auto, m_sel, m_on};
   endfunction

   function automatic logic [7:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0: return exp_ctrl();
         2'd1: return m_range;
         2'd2: return {4'h0, m_rds};
         default: return 8'h00;
      endcase
   endfunction

   // model of one write, applied before the write lands
   task automatic model_write(input logic [1:0] a, input logic [7:0] d);
      case (a)
         2'd0: begin
            m_sel  = d[0] & d[1] & (m_range != 8'h00);
            m_on   = d[0];
            m_auto = d[2];
            m_ie   = d[3];
            if (d[4]) m_flag = 1'b0;
         end
         2'd1: if (!m_on) m_range = d;
         2'd2: if (!m_on) m_rds = d[3:0];
         default: ;
      endcase
   endtask

   // called at a falling edge; returns at a falling edge
   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic read_check(input string req, input logic [1:0] a);
      logic [7:0] v;
      bus_read(a, v);
      check(req, v, exp_read(a));
   endtask

   task automatic run_ticks(input int n, output int pulses);
      pulses = 0;
      ref_tick = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); @(negedge clk);
         if (ref_div_tick) pulses++;
      end
      ref_tick = 1'b0;
   endtask

   task automatic wait_edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got 0x00 expected 0x01");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int p;
      logic [7:0] v;
      void'($urandom(32'd4711));
      m_on = 0; m_sel = 0; m_auto = 0; m_ie = 0; m_flag = 0;
      m_range = 8'h40; m_rds = 4'h1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      read_check("R1 ctrl", 2'd0);
      read_check("R1 range", 2'd1);
      read_check("R1 refdiv", 2'd2);
      read_check("R1 unused", 2'd3);
      check("R1 vco_mult", vco_mult, 8'h40);

      // R3 reset code 1: pulse on every strobe
      run_ticks(6, p);
      check("R3 code1 pulses", 8'(p), 8'd6);

      // R2 upper bits
      bus_write(2'd2, 8'hF7);
      bus_read(2'd2, v); check("R2 upper bits zero", v, 8'h07);

      // R4 / R5 interlocks
      bus_write(2'd0, 8'h01);
      bus_write(2'd2, 8'h03);
      bus_read(2'd2, v); check("R4 refdiv locked", v, 8'h07);
      bus_write(2'd1, 8'h11);
      bus_read(2'd1, v); check("R5 range locked", v, 8'h40);
      check("R5 vco_mult held", vco_mult, 8'h40);

      // R7 refuse VCO with zero range
      bus_write(2'd0, 8'h00);
      bus_write(2'd1, 8'h00);
      bus_write(2'd0, 8'h03);
      bus_read(2'd0, v); check("R7 sel refused", v, 8'h01);
      check("R7 base_sel pin", {7'd0, base_sel}, 8'h00);
      bus_write(2'd0, 8'h00);
      bus_write(2'd1, 8'h20);
      bus_write(2'd0, 8'h03);
      bus_read(2'd0, v); check("R7 sel accepted", v, 8'h03);
      check("R6 base_sel pin", {7'd0, base_sel}, 8'h01);
      // R6 clearing enable clears select
      bus_write(2'd0, 8'h02);
      bus_read(2'd0, v); check("R6 off clears sel", v, 8'h00);

      // R8 rising lock with auto, timing
      bus_write(2'd0, 8'h04);
      lock_in = 1'b1;
      wait_edges(2);
      bus_read(2'd0, v); check("R8 flag not yet", v, 8'h04);
      wait_edges(1);
      bus_read(2'd0, v); check("R8 flag on rise", v, 8'h14);
      check("R9 no irq without enable", {7'd0, irq_req}, 8'h00);
      m_flag = 1'b1;
      // R10 clear
      bus_write(2'd0, 8'h14);
      bus_read(2'd0, v); check("R10 w1c", v, 8'h04);
      bus_write(2'd0, 8'h04);
      bus_read(2'd0, v); check("R10 write 0 keeps", v, 8'h04);
      // R8 falling
      lock_in = 1'b0;
      wait_edges(3);
      bus_read(2'd0, v); check("R8 flag on fall", v, 8'h14);
      m_flag = 1'b1;
      bus_write(2'd0, 8'h0C);
      check("R9 irq raised", {7'd0, irq_req}, 8'h01);
      // auto off: no set
      bus_write(2'd0, 8'h18);
      lock_in = 1'b1;
      wait_edges(5);
      bus_read(2'd0, v); check("R8 no auto no flag", v, 8'h08);
      check("R9 irq low", {7'd0, irq_req}, 8'h00);
      // R10 set wins: clear lands on the setting edge
      bus_write(2'd0, 8'h04);
      lock_in = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      wr_en = 1'b1; addr = 2'd0; wdata = 8'h14;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      bus_read(2'd0, v); check("R10 set wins", v, 8'h14);
      bus_write(2'd0, 8'h10);
      m_flag = 1'b0;

      // R3 code 0 behaves as 1
      bus_write(2'd2, 8'h00);
      wait_edges(1);
      run_ticks(5, p);
      check("R3 code0 as 1", 8'(p), 8'd5);
      // R3 factor 5
      bus_write(2'd2, 8'h05);
      wait_edges(1);
      run_ticks(20, p);
      check("R3 divide by 5", 8'(p), 8'd4);
      // R3 reload on change
      bus_write(2'd2, 8'h03);
      wait_edges(1);
      run_ticks(2, p);
      bus_write(2'd2, 8'h05);
      wait_edges(1);
      run_ticks(4, p);
      check("R3 reload no early pulse", 8'(p), 8'd0);
      run_ticks(1, p);
      check("R3 reload pulse at 5", 8'(p), 8'd1);

      // random register traffic against the model (R2 R4 R5 R6 R7)
      for (int i = 0; i < 300; i++) begin
         logic [1:0] a;
         logic [7:0] d;
         a = 2'($urandom % 4);
         d = 8'($urandom);
         if (a == 2'd1 && ($urandom % 4) == 0) d = 8'h00;
         if (a == 2'd0) d[4] = 1'b0;
         bus_write(a, d);
         read_check("R2/R4/R5 random refdiv", 2'd2);
         read_check("R5 random range", 2'd1);
         read_check("R6/R7 random ctrl", 2'd0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule